// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the front end of an accumulator machine whose memory word is 40 bits wide and carries two 20-bit instructions. It owns the program counter, the memory address register, the memory buffer register, the instruction register and a one-entry buffer for the second instruction of a word. When no buffered instruction is waiting, it reads the word at the program counter from a synchronous memory port. It sends the first (left) instruction to the execute stage and keeps the second (right) one, so the following instruction is issued with no memory access at all.

Each instruction goes to the execute stage as an 8-bit opcode and a 12-bit address. The sequencer then waits until that stage reports completion. The completion strobe can also carry a redirect: a target word and a flag that picks the half of that word to resume at. Fetching and executing strictly alternate. Words are transferred into the instruction register over one path from the memory buffer register, so parking the right half and loading the left half take two separate steps.

Both streams use a valid/ready style handshake. For memory reads, `mem_req` is the valid and `mem_valid` is the response. Once raised, `mem_req` stays high with `mem_addr` unchanged until `mem_valid` is seen at a clock edge, and memory may stretch that wait over any number of cycles. For issue, `ex_valid` is the valid and `ex_done` is the ready. `ex_opcode` and `ex_addr` hold still until `ex_done` is sampled high. If the program counter or a redirect target reaches the memory depth, the sequencer stops and raises a sticky error.

Top module: `dual_slot_fetch`

## Requirements
- R1: While reset is held, `err_o`, `ex_valid` and `mem_req` are all 0. The first memory read after reset is at word 0.
- R2: Word bit 39 is the most significant. The left instruction is bits 39..20, with its opcode in bits 39..32 and its address in bits 31..20. The right instruction is bits 19..0, with its opcode in bits 19..12 and its address in bits 11..0.
- R3: After a word is read, its left instruction is issued first. Its right instruction is issued next with no memory read in between.
- R4: Reads with no redirect go to consecutive word addresses. The program counter advances by one for each word read and does not change when a buffered right instruction is used.
- R5: `mem_req` stays high with `mem_addr` unchanged until `mem_valid`, for any response latency of one cycle or more.
- R6: `ex_valid`, `ex_opcode` and `ex_addr` stay unchanged until `ex_done`. `mem_req` is never high while `ex_valid` is high.
- R7: A redirect with `br_right`=0 that comes with `ex_done` throws away any buffered right instruction. The next instruction is then the left half of the target word, read from memory.
- R8: A redirect with `br_right`=1 reads the target word and issues its right half. The word after it is then read and its left half is issued, so the skipped word leaves nothing in the buffer.
- R9: A redirect target of DEPTH (1000) or more sets `err_o` and stops the sequencer. No further `mem_req` or `ex_valid` follows.
- R10: Once the right half of word DEPTH-1 has completed with no redirect, `err_o` is set and the sequencer stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Read request (valid) |
| mem_addr | output | 10 | Word address of the read |
| mem_valid | input | 1 | Read data present this cycle |
| mem_data | input | 40 | Read data word |
| ex_valid | output | 1 | Instruction offered to execute stage |
| ex_opcode | output | 8 | Opcode of offered instruction |
| ex_addr | output | 12 | Address field of offered instruction |
| ex_done | input | 1 | Execute stage finished (ready) |
| br_take | input | 1 | Redirect, sampled with ex_done |
| br_target | input | 12 | Redirect target word |
| br_right | input | 1 | Resume at right half of target |
| err_o | output | 1 | Sticky address error, sequencer halted |

## Verification
The bench first runs through every word of memory with no redirects. The memory model returns a value computed from the address, with a read latency of one to three cycles depending on the address, and the execute stage holds each instruction for zero to two extra cycles. This run tells a correct field split apart from swapped halves or shifted fields, and tells the buffered right issue apart from a needless second read. It ends with the halt after the last word. Separate runs after reset redirect to left and right halves while the buffer is full and while it is empty, and redirect to targets of exactly DEPTH and far beyond it. These runs show whether the buffer is flushed and whether the skip-left step leaves it unloaded, and they pin down the exact limit of the address check.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int FS_WORD_W = 40;
  localparam int FS_OP_W   = 8;
  localparam int FS_AD_W   = 12;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_WAIT,
    ST_PARK,
    ST_LOAD,
    ST_EXEC,
    ST_HALT
  } fs_state_t;
endpackage

// File: rtl/fs_word_split.sv
module fs_word_split #(
  parameter int WORD_W = 40,
  parameter int OP_W   = 8,
  parameter int AD_W   = 12
) (
  input  logic [WORD_W-1:0]        word_i,
  output logic [1:0][OP_W-1:0]     op_o,
  output logic [1:0][AD_W-1:0]     ad_o
);
  localparam int INS_W = WORD_W / 2;

  // slot 1 = left (upper) half, slot 0 = right (lower) half
  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic [INS_W-1:0] ins;
    assign ins     = word_i[(g+1)*INS_W-1 -: INS_W];
    assign op_o[g] = ins[INS_W-1 -: OP_W];
    assign ad_o[g] = ins[AD_W-1:0];
  end
endmodule

// File: rtl/fs_pc_unit.sv
module fs_pc_unit #(
  parameter int DEPTH = 1000,
  parameter int PCR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic             load_en,
  input  logic [PCR_W-1:0] load_val,
  output logic [PCR_W-1:0] pc_o,
  output logic             pc_bad_o
);
  localparam logic [PCR_W-1:0] LIMIT = PCR_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_o <= '0;
    else if (load_en) pc_o <= load_val;
    else if (inc_en)  pc_o <= pc_o + 1'b1;
  end

  assign pc_bad_o = (pc_o >= LIMIT);
endmodule

// File: rtl/fs_ibr_unit.sv
module fs_ibr_unit #(
  parameter int OP_W = 8,
  parameter int AD_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [OP_W-1:0] load_op,
  input  logic [AD_W-1:0] load_ad,
  input  logic            take_en,
  input  logic            flush_en,
  output logic            full_o,
  output logic [OP_W-1:0] op_o,
  output logic [AD_W-1:0] ad_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      op_o   <= '0;
      ad_o   <= '0;
    end else begin
      if (load_en) begin
        op_o <= load_op;
        ad_o <= load_ad;
      end
      if (flush_en || take_en) full_o <= 1'b0;
      else if (load_en)        full_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_slot_fetch.sv
module dual_slot_fetch
  import fs_pkg::*;
#(
  parameter int DEPTH  = 1000,
  parameter int WORD_W = FS_WORD_W,
  parameter int OP_W   = FS_OP_W,
  parameter int AD_W   = FS_AD_W,
  parameter int PC_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_data,
  output logic              ex_valid,
  output logic [OP_W-1:0]   ex_opcode,
  output logic [AD_W-1:0]   ex_addr,
  input  logic              ex_done,
  input  logic              br_take,
  input  logic [AD_W-1:0]   br_target,
  input  logic              br_right,
  output logic              err_o
);
  localparam int PCR_W = PC_W + 1;
  localparam logic [AD_W-1:0] TGT_LIMIT = AD_W'(DEPTH);

  fs_state_t         state;
  logic [AD_W-1:0]   mar;
  logic [WORD_W-1:0] mbr;
  logic [OP_W-1:0]   ir;
  logic              skip_left;

  logic [1:0][OP_W-1:0] half_op;
  logic [1:0][AD_W-1:0] half_ad;
  logic [PCR_W-1:0]     pc;
  logic                 pc_bad;
  logic                 ibr_full;
  logic [OP_W-1:0]      ibr_op;
  logic [AD_W-1:0]      ibr_ad;

  logic fetch_word, use_ibr, redirect, tgt_bad, park_en;

  assign use_ibr    = (state == ST_FETCH) && ibr_full;
  assign fetch_word = (state == ST_FETCH) && !ibr_full && !pc_bad;
  assign tgt_bad    = (br_target >= TGT_LIMIT);
  assign redirect   = (state == ST_EXEC) && ex_done && br_take && !tgt_bad;
  assign park_en    = (state == ST_PARK);

  fs_word_split #(.WORD_W(WORD_W), .OP_W(OP_W), .AD_W(AD_W)) u_split (
    .word_i (mbr),
    .op_o   (half_op),
    .ad_o   (half_ad)
  );

  fs_pc_unit #(.DEPTH(DEPTH), .PCR_W(PCR_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (fetch_word),
    .load_en  (redirect),
    .load_val (br_target[PCR_W-1:0]),
    .pc_o     (pc),
    .pc_bad_o (pc_bad)
  );

  fs_ibr_unit #(.OP_W(OP_W), .AD_W(AD_W)) u_ibr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (park_en),
    .load_op  (half_op[0]),
    .load_ad  (half_ad[0]),
    .take_en  (use_ibr),
    .flush_en (redirect),
    .full_o   (ibr_full),
    .op_o     (ibr_op),
    .ad_o     (ibr_ad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FETCH;
      mar       <= '0;
      mbr       <= '0;
      ir        <= '0;
      skip_left <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH: begin
          if (ibr_full) begin
            ir    <= ibr_op;
            mar   <= ibr_ad;
            state <= ST_EXEC;
          end else if (pc_bad) begin
            state <= ST_HALT;
          end else begin
            mar   <= AD_W'(pc);
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_valid) begin
            mbr   <= mem_data;
            state <= skip_left ? ST_LOAD : ST_PARK;
          end
        end
        ST_PARK: state <= ST_LOAD;
        ST_LOAD: begin
          ir        <= skip_left ? half_op[0] : half_op[1];
          mar       <= skip_left ? half_ad[0] : half_ad[1];
          skip_left <= 1'b0;
          state     <= ST_EXEC;
        end
        ST_EXEC: begin
          if (ex_done) begin
            if (br_take && tgt_bad) begin
              state <= ST_HALT;
            end else begin
              if (br_take) skip_left <= br_right;
              state <= ST_FETCH;
            end
          end
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_HALT;
      endcase
    end
  end

  assign mem_req   = (state == ST_WAIT);
  assign mem_addr  = mar[PC_W-1:0];
  assign ex_valid  = (state == ST_EXEC);
  assign ex_opcode = ir;
  assign ex_addr   = mar;
  assign err_o     = (state == ST_HALT);
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int DEPTH = 1000,
  parameter int PC_W  = 10,
  parameter int OP_W  = 8,
  parameter int AD_W  = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic [PC_W-1:0] mem_addr,
  input logic            mem_valid,
  input logic            ex_valid,
  input logic [OP_W-1:0] ex_opcode,
  input logic [AD_W-1:0] ex_addr,
  input logic            ex_done,
  input logic            err_o
);
  localparam logic [PC_W:0] LIMIT = (PC_W+1)'(DEPTH);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  a_r6_issue_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_done) |=> (ex_valid && $stable(ex_opcode) && $stable(ex_addr)));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && ex_valid));

  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ({1'b0, mem_addr} < LIMIT));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && !mem_req && !ex_valid));
endmodule

bind dual_slot_fetch fs_checker #(
  .DEPTH(DEPTH), .PC_W(PC_W), .OP_W(OP_W), .AD_W(AD_W)
) u_fs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_valid (mem_valid),
  .ex_valid  (ex_valid),
  .ex_opcode (ex_opcode),
  .ex_addr   (ex_addr),
  .ex_done   (ex_done),
  .err_o     (err_o)
);

// File: tb/tb_dual_slot_fetch.sv
module tb_dual_slot_fetch;
  localparam int DEPTH = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req;
  logic [9:0]  mem_addr;
  logic        mem_valid = 1'b0;
  logic [39:0] mem_data = '0;
  logic        ex_valid;
  logic [7:0]  ex_opcode;
  logic [11:0] ex_addr;
  logic        ex_done = 1'b0;
  logic        br_take = 1'b0;
  logic [11:0] br_target = '0;
  logic        br_right = 1'b0;
  logic        err_o;

  int checks = 0;
  int fails = 0;
  int exp_word;
  bit exp_right;
  bit need_read;

  always #5 clk = ~clk;

  dual_slot_fetch #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data),
    .ex_valid(ex_valid), .ex_opcode(ex_opcode), .ex_addr(ex_addr),
    .ex_done(ex_done), .br_take(br_take), .br_target(br_target),
    .br_right(br_right), .err_o(err_o)
  );

  function automatic logic [39:0] word_of(input int a);
    logic [7:0]  lop, rop;
    logic [11:0] lad, rad;
    lop = 8'(a) ^ 8'hA5;
    lad = 12'(a * 3 + 1);
    rop = 8'(a + 60);
    rad = 12'(4095 - a);
    return {lop, lad, rop, rad};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ex_done = 0; br_take = 0; mem_valid = 0;
    repeat (3) @(negedge clk);
    chk(!err_o && !ex_valid && !mem_req, "R1", {err_o, ex_valid, mem_req}, 0);
    rst_n = 1'b1;
    exp_word = 0; exp_right = 0; need_read = 1;
  endtask

  // Serve memory until an instruction is offered, check it, complete it.
  task automatic do_instr(input bit br, input int tgt, input bit hf,
                          input int hold, input string tag);
    int reads;
    logic [39:0] w;
    logic [7:0]  eop;
    logic [11:0] ead;
    reads = 0;
    while (1) begin
      @(negedge clk);
      mem_valid = 1'b0;
      if (ex_valid || err_o) break;
      if (mem_req) begin
        chk(int'(mem_addr) == exp_word, "R4", mem_addr, exp_word);
        reads++;
        repeat (int'(mem_addr) % 3) @(negedge clk);
        mem_data  = word_of(int'(mem_addr));
        mem_valid = 1'b1;
      end
    end
    w   = word_of(exp_word);
    eop = exp_right ? w[19:12] : w[39:32];
    ead = exp_right ? w[11:0]  : w[31:20];
    chk(ex_valid && !err_o, tag, {err_o, ex_valid}, 1);
    chk(ex_opcode == eop, "R2", ex_opcode, eop);
    chk(ex_addr == ead, "R2", ex_addr, ead);
    chk(reads == (need_read ? 1 : 0), tag, reads, need_read);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(ex_valid && ex_opcode == eop && ex_addr == ead && !mem_req, "R6", ex_opcode, eop);
    end
    ex_done = 1'b1; br_take = br; br_target = 12'(tgt); br_right = hf;
    @(negedge clk);
    ex_done = 1'b0; br_take = 1'b0;
    if (br) begin
      exp_word = tgt; exp_right = hf; need_read = 1;
    end else if (!exp_right) begin
      exp_right = 1; need_read = 0;
    end else begin
      exp_word++; exp_right = 0; need_read = 1;
    end
  endtask

  task automatic expect_halt(input string tag);
    bit quiet;
    quiet = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (mem_req || ex_valid) quiet = 0;
    end
    chk(quiet, tag, 0, 1);
    chk(err_o == 1'b1, tag, err_o, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R3 R4 R10: straight run over all of memory
    do_reset();
    for (int i = 0; i < 2 * DEPTH; i++) do_instr(0, 0, 0, i % 3, "R3");
    expect_halt("R10");

    // R7 R8: redirects with full and empty buffer
    do_reset();
    do_instr(0, 0, 0, 0, "R3");
    do_instr(0, 0, 0, 1, "R3");
    do_instr(1, 500, 0, 0, "R3");     // left of word 1, right still buffered
    do_instr(0, 0, 0, 0, "R7");       // left of 500, read
    do_instr(0, 0, 0, 2, "R3");       // right of 500, buffered
    do_instr(1, 700, 1, 0, "R3");     // left of 501
    do_instr(0, 0, 0, 1, "R8");       // right of 700
    do_instr(0, 0, 0, 0, "R8");       // left of 701, must read
    do_instr(1, 999, 1, 0, "R3");     // right of 701, buffered
    do_instr(0, 0, 0, 0, "R8");       // right of 999
    expect_halt("R10");

    // R9: target exactly at the limit
    do_reset();
    do_instr(1, DEPTH, 0, 0, "R3");
    expect_halt("R9");

    // R9: target far above the limit, from the right slot
    do_reset();
    do_instr(0, 0, 0, 0, "R3");
    do_instr(1, 4095, 1, 1, "R3");
    expect_halt("R9");

    // R7: redirect to the last legal word, left half
    do_reset();
    do_instr(1, DEPTH - 1, 0, 0, "R3");
    do_instr(0, 0, 0, 0, "R7");
    do_instr(0, 0, 0, 0, "R3");
    expect_halt("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule